// File: doc/BRIEF.md
# Coprocessor Status Byte and Interrupt Controller

This block keeps the 8-bit status byte of a floating-point coprocessor and drives two interrupt lines to the host. The execution unit signals when a command starts and when it finishes. At the finish it also presents the result conditions: exponent overflow, exponent underflow, divide-by-zero, zero result and negative result. The host reads the status byte through its own port decode. That decode gives this block a one-cycle read strobe, and the strobe acknowledges both interrupts.

A two-state controller follows the command. `ST_IDLE` moves to `ST_BUSY` on transition `T_START`, which is a command start. `ST_BUSY` returns to `ST_IDLE` on transition `T_FINISH`, which is a completion. Only a completion seen in `ST_BUSY` is accepted. It updates the flags and raises the completion interrupt. The three error bits are sticky. Only a completion marked as the clear-status command, or reset, removes them. The zero and sign bits are replaced by every accepted completion.

Status byte layout: bit 7 busy, bit 6 negative, bit 5 zero, bit 4 reserved, bit 3 divide-by-zero, bit 2 underflow, bit 1 overflow, bit 0 reserved.

Top module: `fpc_status_top`

## Requirements
- R1: After reset the status byte is 0x00 and both interrupt outputs are low.
- R2: In `ST_IDLE`, a start pulse sets status bit 7 from the next cycle. A start pulse in `ST_BUSY` has no effect.
- R3: A completion in `ST_BUSY` clears bit 7 in the next cycle. It also loads bit 5 from the zero strobe and bit 6 from the negative strobe, replacing their old values.
- R4: On an accepted completion, bits 1, 2 and 3 take the OR of their old value and the overflow, underflow and divide-by-zero strobes. A new command start leaves them unchanged.
- R5: An accepted completion with the clear-status input high clears bits 1, 2, 3, 5 and 6. It ignores the condition strobes.
- R6: Reserved bits 0 and 4 always read 0.
- R7: The completion interrupt rises in the cycle after an accepted completion. It stays high until a status read.
- R8: The error interrupt rises in the cycle after an accepted, non-clear completion with any of overflow, underflow or divide-by-zero strobed. A clean completion leaves it unchanged.
- R9: A status read strobe without an accepted completion in the same cycle drops both interrupts in the next cycle. It leaves the status byte unchanged.
- R10: When a read strobe and an accepted completion fall in the same cycle, the completion wins and its interrupts are asserted.
- R11: A completion pulse in `ST_IDLE` is ignored: the status byte and both interrupts are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle pulse: a command begins |
| cmd_done | input | 1 | One-cycle pulse: the current command ends |
| cmd_is_clear | input | 1 | Qualifies cmd_done as the clear-status command |
| cond_ovf | input | 1 | Exponent overflow, valid with cmd_done |
| cond_unf | input | 1 | Exponent underflow, valid with cmd_done |
| cond_dz | input | 1 | Divide-by-zero, valid with cmd_done |
| cond_zero | input | 1 | Result all zeros, valid with cmd_done |
| cond_neg | input | 1 | Result negative, valid with cmd_done |
| stat_rd | input | 1 | One-cycle status read strobe |
| status_o | output | 8 | Status byte |
| irq_end_o | output | 1 | Completion interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
The assertions assume that the start, completion and read inputs are single-cycle strobes. They also assume that the condition strobes matter only in a cycle with cmd_done. The properties are written so that they hold for any mix of these strobes, including illegal overlaps such as a start and a completion in one cycle. The directed stimulus raises each strobe for exactly one clock and returns it to zero. It deliberately combines a read with a completion, and a completion with the idle state, only in the scenarios that target R10 and R11.

// File: rtl/fpc_status_pkg.sv
package fpc_status_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } fpc_state_e;

    localparam int STAT_W   = 8;
    localparam int B_OVF    = 1;
    localparam int B_UNF    = 2;
    localparam int B_DZ     = 3;
    localparam int B_ZERO   = 5;
    localparam int B_NEG    = 6;
    localparam int B_BUSY   = 7;
    localparam int ERR_W    = 3;

    typedef struct packed {
        logic neg;
        logic zero;
        logic dz;
        logic unf;
        logic ovf;
    } fpc_cond_t;
endpackage

// File: rtl/fpc_status_fsm.sv
module fpc_status_fsm
    import fpc_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o,
    output logic accept_o
);
    fpc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_BUSY;   // T_START
            ST_BUSY: if (done_i)  state_d = ST_IDLE;   // T_FINISH
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy_o   = 1'b0;
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = 1'b0;
            end
            ST_BUSY: begin
                busy_o   = 1'b1;
                accept_o = done_i;
            end
            default: begin
                busy_o   = 1'b0;
                accept_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fpc_status_flags.sv
module fpc_status_flags
    import fpc_status_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic            clear_i,
    input  fpc_cond_t       cond_i,
    output logic [ERR_W-1:0] err_o,
    output logic            zero_o,
    output logic            neg_o,
    output logic            err_now_o
);
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_in;
    logic             zero_q, neg_q;

    assign err_in    = {cond_i.dz, cond_i.unf, cond_i.ovf};
    assign err_now_o = accept_i && !clear_i && (|err_in);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            zero_q <= 1'b0;
            neg_q  <= 1'b0;
        end else if (accept_i) begin
            if (clear_i) begin
                err_q  <= '0;
                zero_q <= 1'b0;
                neg_q  <= 1'b0;
            end else begin
                err_q  <= err_q | err_in;
                zero_q <= cond_i.zero;
                neg_q  <= cond_i.neg;
            end
        end
    end

    assign err_o  = err_q;
    assign zero_o = zero_q;
    assign neg_o  = neg_q;
endmodule

// File: rtl/fpc_status_irq.sv
module fpc_status_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic err_now_i,
    input  logic rd_i,
    output logic irq_end_o,
    output logic irq_err_o
);
    logic end_q, err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (accept_i)  end_q <= 1'b1;
            else if (rd_i) end_q <= 1'b0;
            if (err_now_i) err_q <= 1'b1;
            else if (rd_i) err_q <= 1'b0;
        end
    end

    assign irq_end_o = end_q;
    assign irq_err_o = err_q;
endmodule

// File: rtl/fpc_status_top.sv
module fpc_status_top
    import fpc_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_done,
    input  logic       cmd_is_clear,
    input  logic       cond_ovf,
    input  logic       cond_unf,
    input  logic       cond_dz,
    input  logic       cond_zero,
    input  logic       cond_neg,
    input  logic       stat_rd,
    output logic [7:0] status_o,
    output logic       irq_end_o,
    output logic       irq_err_o
);
    logic             busy, accept, err_now, zero_f, neg_f;
    logic [ERR_W-1:0] err_f;
    fpc_cond_t        cond;

    assign cond = '{neg: cond_neg, zero: cond_zero, dz: cond_dz,
                    unf: cond_unf, ovf: cond_ovf};

    fpc_status_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(cmd_start), .done_i(cmd_done),
        .busy_o(busy), .accept_o(accept)
    );

    fpc_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .clear_i(cmd_is_clear),
        .cond_i(cond), .err_o(err_f), .zero_o(zero_f), .neg_o(neg_f),
        .err_now_o(err_now)
    );

    fpc_status_irq u_irq (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .err_now_i(err_now),
        .rd_i(stat_rd), .irq_end_o(irq_end_o), .irq_err_o(irq_err_o)
    );

    always_comb begin
        status_o                   = '0;
        status_o[B_BUSY]           = busy;
        status_o[B_NEG]            = neg_f;
        status_o[B_ZERO]           = zero_f;
        status_o[B_DZ:B_OVF]       = err_f;
    end
endmodule

// File: rtl/fpc_status_chk.sv
module fpc_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       cmd_done,
    input logic       stat_rd,
    input logic [7:0] status_o,
    input logic       irq_end_o,
    input logic       irq_err_o
);
    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] == 1'b0 && status_o[4] == 1'b0);

    p_busy_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !status_o[7] && !cmd_done) |=> status_o[7]);

    p_finish_clears_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && status_o[7]) |=> !status_o[7]);

    p_end_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && status_o[7]) |=> irq_end_o);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(cmd_done && status_o[7])) |=> (!irq_end_o && !irq_err_o));

    p_sticky_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_done) |=> $stable(status_o[3:1]));

    p_idle_done_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !status_o[7] && !cmd_start && !stat_rd)
        |=> ($stable(status_o) && $stable(irq_end_o) && $stable(irq_err_o)));
endmodule

bind fpc_status_top fpc_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_done(cmd_done),
    .stat_rd(stat_rd), .status_o(status_o), .irq_end_o(irq_end_o),
    .irq_err_o(irq_err_o)
);

// File: tb/fpc_status_top_tb.sv
module fpc_status_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_done = 0, cmd_is_clear = 0;
    logic cond_ovf = 0, cond_unf = 0, cond_dz = 0, cond_zero = 0, cond_neg = 0;
    logic stat_rd = 0;
    logic [7:0] status_o;
    logic irq_end_o, irq_err_o;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fpc_status_top u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // drive one cycle of strobes at negedge, return at next negedge (outputs updated)
    task automatic cyc(input logic st, input logic dn, input logic clr,
                       input logic [4:0] cnd, input logic rd);
        cmd_start = st; cmd_done = dn; cmd_is_clear = clr; stat_rd = rd;
        {cond_neg, cond_zero, cond_dz, cond_unf, cond_ovf} = cnd;
        @(negedge clk);
        cmd_start = 0; cmd_done = 0; cmd_is_clear = 0; stat_rd = 0;
        {cond_neg, cond_zero, cond_dz, cond_unf, cond_ovf} = '0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 status", status_o, 8'h00);
        chk("R1 irqs", {6'b0, irq_end_o, irq_err_o}, 8'h00);
    endtask

    task automatic t_busy_and_clean();
        cyc(1, 0, 0, 5'b0, 0);
        chk("R2 busy set", status_o, 8'h80);
        cyc(1, 0, 0, 5'b0, 0);
        chk("R2 start while busy", status_o, 8'h80);
        cyc(0, 1, 0, 5'b10000, 0);              // negative result
        chk("R3 busy clear, neg", status_o, 8'h40);
        chk("R7 end irq", {7'b0, irq_end_o}, 8'h01);
        chk("R8 no err irq clean", {7'b0, irq_err_o}, 8'h00);
        cyc(0, 0, 0, 5'b0, 0);
        chk("R7 end irq held", {7'b0, irq_end_o}, 8'h01);
        cyc(0, 0, 0, 5'b0, 1);
        chk("R9 read clears end", {6'b0, irq_end_o, irq_err_o}, 8'h00);
        chk("R9 read keeps status", status_o, 8'h40);
    endtask

    task automatic t_sticky_errors();
        cyc(1, 0, 0, 5'b0, 0);
        cyc(0, 1, 0, 5'b00001, 0);              // overflow
        chk("R4 ovf bit1", status_o, 8'h02);
        chk("R8 err irq", {6'b0, irq_end_o, irq_err_o}, 8'h03);
        cyc(1, 0, 0, 5'b0, 0);
        chk("R4 start keeps sticky", status_o, 8'h82);
        cyc(0, 1, 0, 5'b01100, 0);              // zero + dz
        chk("R4 OR dz, R3 zero", status_o, 8'h2A);
        chk("R6 reserved bits", status_o & 8'h11, 8'h00);
        cyc(1, 0, 0, 5'b0, 0);
        cyc(0, 1, 0, 5'b00010, 0);              // underflow, zero replaced
        chk("R4 unf, R3 zero replaced", status_o, 8'h0E);
        cyc(0, 0, 0, 5'b0, 1);
        chk("R9 read clears both", {6'b0, irq_end_o, irq_err_o}, 8'h00);
    endtask

    task automatic t_clear();
        cyc(1, 0, 0, 5'b0, 0);
        cyc(0, 1, 1, 5'b11111, 0);
        chk("R5 clear cmd", status_o, 8'h00);
        chk("R5 clear irqs end only", {6'b0, irq_end_o, irq_err_o}, 8'h02);
        cyc(0, 0, 0, 5'b0, 1);
    endtask

    task automatic t_collide();
        cyc(1, 0, 0, 5'b0, 0);
        cyc(0, 1, 0, 5'b00100, 1);              // dz with read same cycle
        chk("R10 completion wins", {6'b0, irq_end_o, irq_err_o}, 8'h03);
        chk("R10 status", status_o, 8'h08);
    endtask

    task automatic t_idle_done();
        cyc(0, 1, 0, 5'b11111, 0);
        chk("R11 status unchanged", status_o, 8'h08);
        chk("R11 irqs unchanged", {6'b0, irq_end_o, irq_err_o}, 8'h03);
        cyc(0, 0, 0, 5'b0, 1);
        cyc(0, 1, 0, 5'b00001, 0);
        chk("R11 no irq from idle", {6'b0, irq_end_o, irq_err_o}, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_busy_and_clean();
        t_sticky_errors();
        t_clear();
        t_collide();
        t_idle_done();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule